// File: doc/BRIEF.md
# Programmable Digital Ramp Generator

This block produces a sweeping 32-bit control value that a synthesizer core can use to modulate its frequency, phase or amplitude. Each cycle of the sweep is made of discrete steps. A 32-bit accumulator moves by one step each time a 16-bit interval counter expires, and that counter is paced by a fixed divide-by-four prescaler. The climbing and descending directions each have their own step size and their own interval. A direction input selects which pair applies.

A limit stage sits inside the accumulator's feedback loop, so the value never leaves the programmed window while the ramp runs. Clearing the accumulator therefore lands it on the floor value. Software writes three packed configuration words and three control bits into shadow inputs. A single update strobe moves them into the working set. Two narrower views of the value are provided for phase and amplitude destinations. An edge flag reports when the sweep is pinned at the limit it is heading toward.

Top module: `ramp_gen`

## Requirements
- R1: After reset, `ramp_o`, `phase_o`, `amp_o` and `at_limit_o` are all zero.
- R2: The words and control bits take effect only at a clock edge where `update_i` is high. Changing them at any other time does not alter the step size, the interval or the limits in use.
- R3: With `dir_i` high, the value rises by the climb step (`step_word_i[31:0]`) once every 4·P cycles. P is `rate_word_i[15:0]`.
- R4: With `dir_i` low, the value falls by the descent step (`step_word_i[63:32]`, an unsigned amount that is subtracted) once every 4·N cycles. N is `rate_word_i[31:16]`.
- R5: A rising step that would pass the ceiling (`limit_word_i[63:32]`), including one that wraps past 2^32, leaves the value at the ceiling. `at_limit_o` is high while the ramp rises and sits at the ceiling.
- R6: A falling step that would pass the floor (`limit_word_i[31:0]`) leaves the value at the floor. `at_limit_o` is high while the ramp falls and sits at the floor.
- R7: An update that loads the clear bit set, with enable set, puts the floor value on `ramp_o` at that same edge.
- R8: A change of `dir_i` restarts the interval counter. The first step in the new direction comes 4 × (new interval) cycles after the edge that sees the change.
- R9: An update with `reload_on_upd_i` high restarts the interval counter. An update with it low, while the ramp is already enabled, leaves the step schedule unchanged.
- R10: An update that turns enable on restarts the interval counter. While disabled, `ramp_o` and the interval counter hold their values and `at_limit_o` is low.
- R11: An interval field of 0 behaves as 1, giving one step every 4 cycles.
- R12: `phase_o` is the upper 16 bits of `ramp_o`. `amp_o` is the upper 14 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_word_i | input | 32 | Shadow intervals: descent interval in [31:16], climb interval in [15:0] |
| step_word_i | input | 64 | Shadow step sizes: descent in [63:32], climb in [31:0] |
| limit_word_i | input | 64 | Shadow limits: ceiling in [63:32], floor in [31:0] |
| enable_i | input | 1 | Shadow ramp enable |
| clear_i | input | 1 | Shadow accumulator clear |
| reload_on_upd_i | input | 1 | Restart the interval counter at this update |
| update_i | input | 1 | Moves all shadow inputs into the working set |
| dir_i | input | 1 | 1 = climb, 0 = descend |
| ramp_o | output | 32 | Ramp value |
| phase_o | output | 16 | Upper 16 bits of the ramp value |
| amp_o | output | 14 | Upper 14 bits of the ramp value |
| at_limit_o | output | 1 | Pinned at the limit in the current direction |

## Verification
The sweep is run with several input patterns, and each one separates a different fault:
- Unequal climb and descent intervals and steps show whether the direction input picks the right pair.
- A direction flip in the middle of an interval shows whether the counter restarts or keeps its old count.
- Updates placed in the middle of an interval, with and without the reload option, show whether an update restarts the schedule only when it should.
- A re-enable after a pause, with the counter stopped part-way, catches a counter that resumes instead of restarting.
- A climb step that wraps past 2^32, and a descent that reaches the floor exactly, exercise both clamp paths.
- Zero intervals and a clear that moves the floor test the two remaining corner cases.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
    localparam int unsigned RAMP_W = 32;
    localparam int unsigned TMR_W  = 16;

    typedef logic [RAMP_W-1:0] ramp_t;
    typedef logic [TMR_W-1:0]  ivl_t;

    // Working configuration after unpacking the shadow words.
    typedef struct packed {
        ivl_t  fall_ivl;
        ivl_t  rise_ivl;
        ramp_t fall_step;
        ramp_t rise_step;
        ramp_t lim_hi;
        ramp_t lim_lo;
        logic  en;
        logic  clr;
    } ramp_cfg_t;

    // R11: an interval of zero counts as one.
    function automatic ivl_t ivl_floor(ivl_t v);
        return (v == '0) ? ivl_t'(1) : v;
    endfunction
endpackage

// File: rtl/ramp_shadow.sv
module ramp_shadow
    import ramp_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [2*TMR_W-1:0]  rate_word_i,
    input  logic [2*RAMP_W-1:0] step_word_i,
    input  logic [2*RAMP_W-1:0] limit_word_i,
    input  logic                enable_i,
    input  logic                clear_i,
    input  logic                reload_on_upd_i,
    input  logic                update_i,
    output ramp_cfg_t           act_d_o,
    output logic                en_q_o,
    output logic                clr_q_o,
    output ramp_t               lo_q_o,
    output ramp_t               hi_q_o,
    output logic                upd_reload_o
);
    ramp_cfg_t act_d, act_q;
    logic      upd_reload;

    // R2: the working set changes only on the update strobe.
    always_comb begin
        act_d      = act_q;
        upd_reload = 1'b0;
        if (update_i) begin
            act_d.fall_ivl  = rate_word_i[2*TMR_W-1:TMR_W];
            act_d.rise_ivl  = rate_word_i[TMR_W-1:0];
            act_d.fall_step = step_word_i[2*RAMP_W-1:RAMP_W];
            act_d.rise_step = step_word_i[RAMP_W-1:0];
            act_d.lim_hi    = limit_word_i[2*RAMP_W-1:RAMP_W];
            act_d.lim_lo    = limit_word_i[RAMP_W-1:0];
            act_d.en        = enable_i;
            act_d.clr       = clear_i;
            // R9 / R10: option bit or an enable turning on
            upd_reload      = reload_on_upd_i | (enable_i & ~act_q.en);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) act_q <= '0;
        else         act_q <= act_d;
    end

    assign act_d_o      = act_d;
    assign en_q_o       = act_q.en;
    assign clr_q_o      = act_q.clr;
    assign lo_q_o       = act_q.lim_lo;
    assign hi_q_o       = act_q.lim_hi;
    assign upd_reload_o = upd_reload;
endmodule

// File: rtl/ramp_timer.sv
module ramp_timer #(
    parameter int unsigned PRESCALE = 4,
    parameter int unsigned TMR_W    = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             hold_i,
    input  logic             reload_i,
    input  logic [TMR_W-1:0] ivl_i,
    output logic             fire_o
);
    localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [TMR_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t          st_d, st_q;
    logic             fire;
    logic [TMR_W-1:0] ivl_eff;

    always_comb begin
        st_d    = st_q;
        fire    = 1'b0;
        ivl_eff = (ivl_i == '0) ? TMR_W'(1) : ivl_i;   // R11
        if (run_i) begin
            if (hold_i || reload_i) begin
                // R8 / R9 / R10: restart the interval
                st_d.pre = '0;
                st_d.cnt = ivl_eff;
            end else if (st_q.pre == PRE_LAST) begin
                st_d.pre = '0;
                if (st_q.cnt <= TMR_W'(1)) begin
                    fire     = 1'b1;
                    st_d.cnt = ivl_eff;
                end else begin
                    st_d.cnt = st_q.cnt - TMR_W'(1);
                end
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
        end
        // R10: when not running, everything holds
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign fire_o = fire;
endmodule

// File: rtl/ramp_accum.sv
module ramp_accum #(
    parameter int unsigned RAMP_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              clr_i,
    input  logic              fire_i,
    input  logic              dir_i,
    input  logic [RAMP_W-1:0] rise_step_i,
    input  logic [RAMP_W-1:0] fall_step_i,
    input  logic [RAMP_W-1:0] lo_i,
    input  logic [RAMP_W-1:0] hi_i,
    output logic [RAMP_W-1:0] acc_o
);
    logic [RAMP_W-1:0] acc_d, acc_q;
    logic [RAMP_W:0]   cand;
    logic              wrap;

    always_comb begin
        acc_d = acc_q;
        cand  = {1'b0, acc_q};
        if (fire_i) begin
            if (dir_i) cand = {1'b0, acc_q} + {1'b0, rise_step_i};   // R3
            else       cand = {1'b0, acc_q} - {1'b0, fall_step_i};   // R4
        end
        wrap = fire_i & cand[RAMP_W];
        if (en_i) begin
            if (clr_i) begin
                acc_d = lo_i;                                         // R7
            end else if (wrap) begin
                acc_d = dir_i ? hi_i : lo_i;                          // R5 / R6
            end else if (cand[RAMP_W-1:0] > hi_i) begin
                acc_d = hi_i;
            end else if (cand[RAMP_W-1:0] < lo_i) begin
                acc_d = lo_i;
            end else begin
                acc_d = cand[RAMP_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) acc_q <= '0;
        else         acc_q <= acc_d;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/ramp_gen.sv
module ramp_gen
    import ramp_pkg::*;
#(
    parameter int unsigned PRESCALE = 4,
    parameter int unsigned PHASE_W  = 16,
    parameter int unsigned AMP_W    = 14
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [2*TMR_W-1:0]  rate_word_i,
    input  logic [2*RAMP_W-1:0] step_word_i,
    input  logic [2*RAMP_W-1:0] limit_word_i,
    input  logic                enable_i,
    input  logic                clear_i,
    input  logic                reload_on_upd_i,
    input  logic                update_i,
    input  logic                dir_i,
    output logic [RAMP_W-1:0]   ramp_o,
    output logic [PHASE_W-1:0]  phase_o,
    output logic [AMP_W-1:0]    amp_o,
    output logic                at_limit_o
);
    typedef struct packed {
        logic dir;
    } top_st_t;

    top_st_t   st_d, st_q;
    ramp_cfg_t act_d;
    logic      en_q, clr_q, upd_reload, dir_chg, fire;
    ramp_t     lo_q, hi_q, acc;
    ivl_t      ivl_sel;

    ramp_shadow u_shadow (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .rate_word_i     (rate_word_i),
        .step_word_i     (step_word_i),
        .limit_word_i    (limit_word_i),
        .enable_i        (enable_i),
        .clear_i         (clear_i),
        .reload_on_upd_i (reload_on_upd_i),
        .update_i        (update_i),
        .act_d_o         (act_d),
        .en_q_o          (en_q),
        .clr_q_o         (clr_q),
        .lo_q_o          (lo_q),
        .hi_q_o          (hi_q),
        .upd_reload_o    (upd_reload)
    );

    always_comb begin
        st_d.dir = dir_i;
        dir_chg  = (dir_i != st_q.dir);                   // R8
        ivl_sel  = dir_i ? act_d.rise_ivl : act_d.fall_ivl;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    ramp_timer #(
        .PRESCALE (PRESCALE),
        .TMR_W    (TMR_W)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (act_d.en),
        .hold_i   (act_d.clr),
        .reload_i (upd_reload | dir_chg),
        .ivl_i    (ivl_sel),
        .fire_o   (fire)
    );

    ramp_accum #(
        .RAMP_W (RAMP_W)
    ) u_accum (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (act_d.en),
        .clr_i       (act_d.clr),
        .fire_i      (fire),
        .dir_i       (dir_i),
        .rise_step_i (act_d.rise_step),
        .fall_step_i (act_d.fall_step),
        .lo_i        (act_d.lim_lo),
        .hi_i        (act_d.lim_hi),
        .acc_o       (acc)
    );

    // R12: truncated views for narrower destinations
    assign ramp_o     = acc;
    assign phase_o    = acc[RAMP_W-1 -: PHASE_W];
    assign amp_o      = acc[RAMP_W-1 -: AMP_W];
    // R5 / R6 / R10: pinned flag follows the registered direction
    assign at_limit_o = en_q & (st_q.dir ? (acc == hi_q) : (acc == lo_q));
endmodule

module ramp_gen_chk
    import ramp_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  upd,
    input logic  cfg_en,
    input logic  cfg_clr,
    input ramp_t cfg_lo,
    input logic  dir_in,
    input logic  dir_q,
    input logic  en_q,
    input logic  clr_q,
    input ramp_t lo_q,
    input ramp_t hi_q,
    input ramp_t ramp
);
    a_r5_within_limits: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && lo_q <= hi_q) |-> (ramp >= lo_q && ramp <= hi_q));

    a_r3_rise_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !clr_q && dir_q && dir_in && !upd && lo_q <= hi_q)
        |=> (ramp >= $past(ramp)));

    a_r4_fall_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !clr_q && !dir_q && !dir_in && !upd && lo_q <= hi_q)
        |=> (ramp <= $past(ramp)));

    a_r7_clear_to_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && cfg_en && cfg_clr) |=> (ramp == $past(cfg_lo)));

    a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !upd) |=> $stable(ramp));
endmodule

bind ramp_gen ramp_gen_chk u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .upd     (update_i),
    .cfg_en  (enable_i),
    .cfg_clr (clear_i),
    .cfg_lo  (limit_word_i[31:0]),
    .dir_in  (dir_i),
    .dir_q   (st_q.dir),
    .en_q    (en_q),
    .clr_q   (clr_q),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .ramp    (ramp_o)
);

// File: tb/ramp_gen_tb_top.sv
module ramp_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rate_w = '0;
    logic [63:0] step_w = '0;
    logic [63:0] lim_w = '0;
    logic        en = 1'b0, clr = 1'b0, rld = 1'b0, upd = 1'b0, dir = 1'b1;
    logic [31:0] ramp;
    logic [15:0] phase;
    logic [13:0] amp;
    logic        over;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        int          at;
        int          kind;   // 0 ramp, 1 flag, 2 phase, 3 amp
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    ramp_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .rate_word_i(rate_w), .step_word_i(step_w),
        .limit_word_i(lim_w), .enable_i(en), .clear_i(clr), .reload_on_upd_i(rld),
        .update_i(upd), .dir_i(dir), .ramp_o(ramp), .phase_o(phase), .amp_o(amp),
        .at_limit_o(over)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] sample(int kind);
        case (kind)
            0: return ramp;
            1: return {31'd0, over};
            2: return {16'd0, phase};
            default: return {18'd0, amp};
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, expv);
        end
    endtask

    // monitor: pops expectations as their cycle arrives
    always @(negedge clk) begin
        exp_t it;
        while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
            it = sb_q.pop_front();
            if (it.at < cyc) chk({it.tag, " (missed slot)"}, 32'hxxxx_xxxx, it.val);
            else             chk(it.tag, sample(it.kind), it.val);
        end
    end

    task automatic expect_at(int k, int kind, logic [31:0] v, string tag);
        exp_t it;
        it.at = cyc + k; it.kind = kind; it.val = v; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wait_until(int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic do_update();
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired at cyc=%0d", cyc);
        finish_run();
    end

    initial begin
        int t1, t2, t3, t4, t5, t6, t7, t8, t9;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ramp after reset", ramp, 32'h0);
        chk("R1 flag after reset", {31'd0, over}, 32'h0);
        chk("R1 phase after reset", {16'd0, phase}, 32'h0);
        chk("R1 amp after reset", {18'd0, amp}, 32'h0);

        // Test A: clear then climb (R7, R3, R12)
        lim_w  = {32'hF000_0000, 32'h1000_0000};
        step_w = {32'h0080_0000, 32'h0100_0000};
        rate_w = {16'd3, 16'd2};
        en = 1'b1; clr = 1'b1; rld = 1'b1;
        do_update();
        chk("R7 clear lands on floor", ramp, 32'h1000_0000);
        clr = 1'b0;
        do_update();
        t1 = cyc;
        expect_at(7,  0, 32'h1000_0000, "R3 no step before 4*P");
        expect_at(8,  0, 32'h1100_0000, "R3 first climb step");
        expect_at(8,  2, 32'h0000_1100, "R12 phase slice");
        expect_at(8,  3, 32'h0000_0440, "R12 amp slice");
        expect_at(16, 0, 32'h1200_0000, "R3 second climb step");
        wait_until(t1 + 17);
        // R2: new shadow step without update has no effect
        step_w = {32'h0080_0000, 32'h0200_0000};
        expect_at(7, 0, 32'h1300_0000, "R2 shadow step ignored");
        wait_until(t1 + 26);

        // Test C/D: direction flip mid-interval, descend to floor (R8, R4, R6)
        dir = 1'b0;
        @(negedge clk);
        t2 = cyc;
        chk("R8 value kept at flip", ramp, 32'h1300_0000);
        expect_at(11, 0, 32'h1300_0000, "R8 no step before 4*N");
        expect_at(12, 0, 32'h1280_0000, "R4 first descent step");
        expect_at(24, 0, 32'h1200_0000, "R4 second descent step");
        expect_at(71, 1, 32'h0, "R6 flag low above floor");
        expect_at(72, 0, 32'h1000_0000, "R6 reaches floor");
        expect_at(72, 1, 32'h1, "R6 flag at floor");
        expect_at(90, 0, 32'h1000_0000, "R6 holds at floor");
        wait_until(t2 + 91);

        // Test E: climb with wrap past 2^32 (R5)
        step_w = {32'h1000_0000, 32'h5000_0000};
        rate_w = {16'd3, 16'd1};
        dir = 1'b1; rld = 1'b1;
        do_update();
        t3 = cyc;
        expect_at(4,  0, 32'h6000_0000, "R5 climb step");
        expect_at(8,  0, 32'hB000_0000, "R5 climb step 2");
        expect_at(8,  1, 32'h0, "R5 flag low below ceiling");
        expect_at(12, 0, 32'hF000_0000, "R5 wrap clamps to ceiling");
        expect_at(12, 1, 32'h1, "R5 flag at ceiling");
        expect_at(16, 0, 32'hF000_0000, "R5 holds at ceiling");
        wait_until(t3 + 17);

        // Test F: disable, hold, re-enable (R10)
        en = 1'b0;
        do_update();
        t4 = cyc;
        chk("R10 value held on disable", ramp, 32'hF000_0000);
        chk("R10 flag low when disabled", {31'd0, over}, 32'h0);
        expect_at(10, 0, 32'hF000_0000, "R10 value held while off");
        wait_until(t4 + 11);
        dir = 1'b0;
        @(negedge clk);
        chk("R10 flip while off ignored", ramp, 32'hF000_0000);
        rate_w = {16'd1, 16'd1};
        en = 1'b1; rld = 1'b0;
        do_update();
        t5 = cyc;
        chk("R10 flag low off-limit", {31'd0, over}, 32'h0);
        expect_at(3, 0, 32'hF000_0000, "R10 no early step after enable");
        expect_at(4, 0, 32'hE000_0000, "R10 step 4 cycles after enable");
        wait_until(t5 + 5);

        // Test G: update with and without reload option (R9)
        rld = 1'b1;
        do_update();
        t6 = cyc;
        expect_at(2, 0, 32'hE000_0000, "R9 reload delays step");
        expect_at(4, 0, 32'hD000_0000, "R9 step after reload");
        wait_until(t6 + 4);
        rld = 1'b0;
        do_update();
        t7 = cyc;
        expect_at(2, 0, 32'hD000_0000, "R9 plain update no restart");
        expect_at(3, 0, 32'hC000_0000, "R9 schedule kept");
        wait_until(t7 + 3);

        // Test H: zero intervals (R11)
        rate_w = 32'h0;
        rld = 1'b1;
        do_update();
        t8 = cyc;
        expect_at(3, 0, 32'hC000_0000, "R11 no step before 4");
        expect_at(4, 0, 32'hB000_0000, "R11 step every 4");
        expect_at(8, 0, 32'hA000_0000, "R11 next step");
        wait_until(t8 + 8);

        // Test I: clear onto a moved floor (R7, R12, R6)
        lim_w = {32'hF000_0000, 32'h2000_0000};
        clr = 1'b1;
        do_update();
        t9 = cyc;
        chk("R7 clear to new floor", ramp, 32'h2000_0000);
        chk("R12 phase of floor", {16'd0, phase}, 32'h0000_2000);
        chk("R12 amp of floor", {18'd0, amp}, 32'h0000_0800);
        chk("R6 flag at floor while descending", {31'd0, over}, 32'h1);
        expect_at(6, 0, 32'h2000_0000, "R7 held while clear set");
        wait_until(t9 + 7);

        finish_run();
    end
endmodule